// File: doc/BRIEF.md
# SDRAM Controller with Periodic Refresh

This block lets a simple single-word host port reach a 32-bit single-data-rate SDRAM with four banks. After reset it holds the memory idle for a settling delay. It then precharges every bank, issues two auto-refresh commands and programs the mode register with a burst length of one, the chosen burst order and the chosen read latency. Only after that does it accept host traffic.

Each host access is a single word. The controller splits the host address into a bank, a row and a column. It opens the row with ACTIVE. It then issues READ or WRITE with auto-precharge, so that no row stays open between accesses. Write byte enables become the per-byte data masks. Read data is captured two or three clocks after the READ, depending on the latency picked while reset is held.

A refresh timer raises a request at a fixed interval. The request is served as soon as the controller is idle, ahead of any new host request. An access already in progress is never cut short. The host sees a single `host_ready` signal that is low whenever a request would not be taken.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is high and for at least PWRUP_CYC cycles after it falls, CKE is high, chip select is high (no command), `host_ready` is low, `host_rvalid` is low and the data bus is not driven.
- R2: The first four commands are, in order: PRECHARGE with A10 high, AUTO REFRESH, AUTO REFRESH, LOAD MODE. They are spaced exactly T_RP, T_RFC and T_RFC cycles apart. `host_ready` stays low until LOAD MODE is T_MRD cycles old.
- R3: The LOAD MODE word on A has A2:A0 = 000 (burst of one), A3 = BURST_ORDER, A6:A4 = 3'd2 or 3'd3 (the read latency) and every other bit zero.
- R4: Host address bits [21:20] are the bank, [19:8] the row and [7:0] the column. ACTIVE carries bank and row. The following READ or WRITE carries the same bank and the column on A7:A0, with A10 high for auto-precharge.
- R5: Command encodings are {RAS#,CAS#,WE#} = 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 AUTO REFRESH, 000 LOAD MODE. A command is valid only when CS# is low, and no two commands are on consecutive cycles. READ or WRITE follows its ACTIVE after at least T_RCD cycles. No other command comes between them.
- R6: During WRITE the data bus is driven with the host word and the mask bit of byte i is the inverse of host byte enable i, so that disabled bytes keep their stored value. The bus is driven in no other cycle.
- R7: `host_rvalid` is a one-cycle pulse T_RCD + 1 + CL cycles after the edge that accepts a read, and `host_rdata` then holds the word read.
- R8: While idle, one AUTO REFRESH is issued per REF_INTERVAL cycles.
- R9: Under an unbroken stream of host requests, consecutive AUTO REFRESH commands are never more than REF_INTERVAL plus one access time apart, because a due refresh goes ahead of new requests.
- R10: `host_ready` is low in the cycle after an accept and stays low until the access has recovered. A request held while ready is low, including during initialisation, starts no command.
- R11: `cfg_cl3` is sampled while reset is high. 1 selects read latency 3 and 0 selects latency 2, for both the mode word and the capture point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all signals on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cl3 | input | 1 | Read latency select, sampled in reset (1 = 3, 0 = 2) |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Word address {bank, row, column} |
| host_wdata | input | 32 | Write word |
| host_be | input | 4 | Byte enables for a write |
| host_ready | output | 1 | Request is accepted on this edge when high |
| host_rvalid | output | 1 | Read word valid pulse |
| host_rdata | output | 32 | Read word |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, low for a command |
| sd_ras_n | output | 1 | Row strobe command bit |
| sd_cas_n | output | 1 | Column strobe command bit |
| sd_we_n | output | 1 | Write enable command bit |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed address |
| sd_dqm | output | 4 | Per-byte data masks, high = masked |
| sd_dq_out | output | 32 | Write data to the pads |
| sd_dq_oe | output | 1 | Drive enable for write data |
| sd_dq_in | input | 32 | Read data from the pads |

## Verification
The bench places a behavioural memory model on the SDRAM pins. The model stores words by decoded {bank, row, column} and answers reads after the latency found in the mode word. Writes to corner addresses (all-zero, all-ones, mixed fields in each bank) are then read back. Because the model's storage key must equal the host address, a field swap in the address split shows up even when the read data round-trips. A partial-byte write over a known word separates correct masking from inverted or ignored masks. An idle window shows the refresh rate. A saturating request stream shows that refresh still wins over new requests. The whole flow is run again with latency 2 to check that the mode word and the capture point move together.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // {RAS#, CAS#, WE#}
  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IREF,
    ST_MRS,
    ST_IDLE,
    ST_RW
  } ctl_state_e;
endpackage

// File: rtl/sdc_addr_map.sv
module sdc_addr_map #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  assign bank = addr[ADDR_W-1 -: BANK_W];
  assign row  = addr[COL_W +: ROW_W];
  assign col  = addr[COL_W-1:0];
endmodule

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
  parameter int INTERVAL = 2080,
  localparam int CNT_W = $clog2(INTERVAL)
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  logic [CNT_W-1:0] cnt;
  logic             due;

  assign due = (cnt == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= due ? '0 : cnt + 1'b1;
      if (due)      pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end

  // an outstanding refresh is never dropped without service
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);
endmodule

// File: rtl/sdc_read_capture.sv
module sdc_read_capture #(
  parameter int DATA_W = 32,
  localparam int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              cl3,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  logic [MAX_CL-1:0] stage;
  logic              tap;

  assign tap = cl3 ? stage[MAX_CL-1] : stage[MAX_CL-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage  <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      stage  <= {stage[MAX_CL-2:0], issue};
      rvalid <= tap;
      if (tap) rdata <= dq_in;
    end
  end

  // single-word reads give a single-cycle valid
  assert_single_beat_R7: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdc_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 32,
  parameter int PWRUP_CYC    = 20000,
  parameter int REF_INTERVAL = 2080,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 2,
  parameter bit BURST_ORDER  = 1'b0,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cl3,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [BE_W-1:0]   host_be,
  output logic              host_ready,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [BE_W-1:0]   sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int AP_BIT = 10;
  localparam int TMR_W  = $clog2(PWRUP_CYC + T_RFC + T_WR + T_RP + 8);

  ctl_state_e        state;
  sd_cmd_e           cmd_q;
  logic [TMR_W-1:0]  tmr;
  logic              iref_second;
  logic              cl3_q;
  logic              rd_issue;
  logic              ref_pend, ref_ack, accept;
  logic [BANK_W-1:0] map_bank, q_bank;
  logic [ROW_W-1:0]  map_row;
  logic [COL_W-1:0]  map_col, q_col;
  logic              q_we;
  logic [DATA_W-1:0] q_wdata;
  logic [BE_W-1:0]   q_be;
  logic [ROW_W-1:0]  col_word, pall_word, mode_word;

  sdc_addr_map #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_map (
    .addr(host_addr), .bank(map_bank), .row(map_row), .col(map_col));

  sdc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend));

  sdc_read_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .issue(rd_issue), .cl3(cl3_q), .dq_in(sd_dq_in),
    .rvalid(host_rvalid), .rdata(host_rdata));

  always_comb begin
    col_word = '0;
    col_word[COL_W-1:0] = q_col;
    col_word[AP_BIT] = 1'b1;
    pall_word = '0;
    pall_word[AP_BIT] = 1'b1;
    mode_word = '0;
    mode_word[3] = BURST_ORDER;
    mode_word[6:4] = cl3_q ? 3'd3 : 3'd2;
  end

  // ready and refresh grant decode only registered state
  assign host_ready = (state == ST_IDLE) && (tmr == '0) && !ref_pend;
  assign ref_ack    = (state == ST_IDLE) && (tmr == '0) && ref_pend;
  assign accept     = host_ready && host_req;
  assign sd_cke     = 1'b1;
  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_PWR;
      tmr         <= TMR_W'(PWRUP_CYC - 1);
      cmd_q       <= CMD_NOP;
      sd_cs_n     <= 1'b1;
      sd_ba       <= '0;
      sd_a        <= '0;
      sd_dqm      <= '0;
      sd_dq_out   <= '0;
      sd_dq_oe    <= 1'b0;
      rd_issue    <= 1'b0;
      iref_second <= 1'b0;
      cl3_q       <= cfg_cl3;
      q_we        <= 1'b0;
      q_bank      <= '0;
      q_col       <= '0;
      q_wdata     <= '0;
      q_be        <= '0;
    end else begin
      cmd_q    <= CMD_NOP;
      sd_cs_n  <= 1'b1;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= '0;
      rd_issue <= 1'b0;
      if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        unique case (state)
          ST_PWR: begin
            cmd_q   <= CMD_PRE;
            sd_cs_n <= 1'b0;
            sd_a    <= pall_word;
            tmr     <= TMR_W'(T_RP - 1);
            state   <= ST_IREF;
          end
          ST_IREF: begin
            cmd_q       <= CMD_REF;
            sd_cs_n     <= 1'b0;
            tmr         <= TMR_W'(T_RFC - 1);
            iref_second <= !iref_second;
            if (iref_second) state <= ST_MRS;
          end
          ST_MRS: begin
            cmd_q   <= CMD_LMR;
            sd_cs_n <= 1'b0;
            sd_ba   <= '0;
            sd_a    <= mode_word;
            tmr     <= TMR_W'(T_MRD - 1);
            state   <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd_q   <= CMD_REF;
              sd_cs_n <= 1'b0;
              tmr     <= TMR_W'(T_RFC - 1);
            end else if (host_req) begin
              cmd_q   <= CMD_ACT;
              sd_cs_n <= 1'b0;
              sd_ba   <= map_bank;
              sd_a    <= map_row;
              q_we    <= host_we;
              q_bank  <= map_bank;
              q_col   <= map_col;
              q_wdata <= host_wdata;
              q_be    <= host_be;
              tmr     <= TMR_W'(T_RCD - 1);
              state   <= ST_RW;
            end
          end
          ST_RW: begin
            sd_cs_n <= 1'b0;
            sd_ba   <= q_bank;
            sd_a    <= col_word;
            state   <= ST_IDLE;
            if (q_we) begin
              cmd_q     <= CMD_WR;
              sd_dq_oe  <= 1'b1;
              sd_dq_out <= q_wdata;
              sd_dqm    <= ~q_be;
              tmr       <= TMR_W'(T_WR + T_RP - 1);
            end else begin
              cmd_q    <= CMD_RD;
              rd_issue <= 1'b1;
              tmr      <= cl3_q ? TMR_W'(3 + T_RP - 1) : TMR_W'(2 + T_RP - 1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_cmd_gap_R5: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n |=> sd_cs_n);
  assert_bus_drive_R6: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |-> (!sd_cs_n && {sd_ras_n, sd_cas_n, sd_we_n} == CMD_WR));
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> !host_ready);
  assert_act_then_col_R5: assert property (@(posedge clk) disable iff (rst)
    (!sd_cs_n && {sd_ras_n, sd_cas_n, sd_we_n} == CMD_ACT) |=> (state == ST_RW));
endmodule

// File: tb/sim_sdram_ctrl.sv
`timescale 1ns/1ps
module sim_sdram_ctrl;
  localparam int PWR = 40, RI = 400, TRCD = 2, TRP = 2, TRFC = 6, TMRD = 2, TWR = 2;

  logic clk = 1'b0, rst = 1'b1, cfg_cl3 = 1'b1;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [21:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  host_be = '0;
  logic host_ready, host_rvalid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [31:0] host_rdata, sd_dq_out, sd_dq_in;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  logic [3:0]  sd_dqm;

  always #2.5 clk = ~clk;

  sdram_ctrl #(.PWRUP_CYC(PWR), .REF_INTERVAL(RI), .T_RCD(TRCD), .T_RP(TRP),
               .T_RFC(TRFC), .T_MRD(TMRD), .T_WR(TWR)) u0 (
    .clk(clk), .rst(rst), .cfg_cl3(cfg_cl3), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // ---------------- memory model on the pins ----------------
  logic [31:0] mem [logic [21:0]];
  logic [11:0] open_row [4];
  logic [11:0] mode_a;
  logic [2:0]  ilog_cmd [4];
  logic [11:0] ilog_a [4];
  int ilog_cyc [4];
  int n_cmd, n_act, n_ref, last_cmd, act_cyc, last_ref, max_ref_gap, viol, a10_bad, rd_cnt;
  bit act_open, rd_pend;
  logic [21:0] rd_idx;

  always @(posedge clk) begin
    logic [2:0] c;
    logic [21:0] idx;
    if (rst) begin
      n_cmd = 0; n_act = 0; n_ref = 0; viol = 0; a10_bad = 0; max_ref_gap = 0;
      act_open = 0; rd_pend = 0; last_cmd = 0; last_ref = 0; mode_a = '0;
      sd_dq_in <= '0;
    end else begin
      if (rd_pend) begin
        if (rd_cnt == 1) begin
          sd_dq_in <= mem.exists(rd_idx) ? mem[rd_idx] : 32'h0;
          rd_pend = 0;
        end else rd_cnt--;
      end
      if (!sd_cs_n) begin
        c = {sd_ras_n, sd_cas_n, sd_we_n};
        if (n_cmd > 0 && cyc == last_cmd + 1) viol++;
        if (n_cmd < 4) begin ilog_cmd[n_cmd] = c; ilog_a[n_cmd] = sd_a; ilog_cyc[n_cmd] = cyc; end
        n_cmd++; last_cmd = cyc;
        case (c)
          3'b011: begin
            if (act_open) viol++;
            open_row[sd_ba] = sd_a; act_open = 1; act_cyc = cyc; n_act++;
          end
          3'b100, 3'b101: begin
            if (!act_open || cyc - act_cyc < TRCD) viol++;
            act_open = 0;
            if (!sd_a[10]) a10_bad++;
            idx = {sd_ba, open_row[sd_ba], sd_a[7:0]};
            if (c == 3'b100) begin
              if (!mem.exists(idx)) mem[idx] = 32'h0;
              for (int b = 0; b < 4; b++)
                if (!sd_dqm[b]) mem[idx][8*b +: 8] = sd_dq_out[8*b +: 8];
            end else begin
              rd_pend = 1; rd_idx = idx; rd_cnt = int'(mode_a[6:4]) - 1;
            end
          end
          3'b001: begin
            if (act_open) viol++;
            if (n_ref >= 2 && cyc - last_ref > max_ref_gap) max_ref_gap = cyc - last_ref;
            n_ref++; last_ref = cyc;
          end
          3'b000: mode_a = sd_a;
          default: ;
        endcase
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic host_access(input logic we, input logic [21:0] addr, input logic [31:0] wd,
                             input logic [3:0] be, input int hold,
                             output logic [31:0] rd, output int lat);
    int g = 0;
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = addr; host_wdata = wd; host_be = be;
    while (!host_ready && g < 5000) begin @(negedge clk); g++; end
    @(posedge clk);
    @(negedge clk);
    chk(host_ready == 0, "R10 ready low after accept", host_ready, 0);
    for (int h = 0; h < hold; h++) @(negedge clk);
    host_req = 0;
    rd = '0; lat = hold;
    if (!we) begin
      while (!host_rvalid && lat < 60) begin @(posedge clk); lat++; @(negedge clk); end
      rd = host_rdata;
      @(negedge clk);
      chk(host_rvalid == 0, "R7 valid is one cycle", host_rvalid, 0);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset(input logic cl3);
    cfg_cl3 = cl3; rst = 1; host_req = 1; host_we = 1; host_addr = 22'h0; host_be = 4'hF;
    repeat (4) @(negedge clk);
    chk(sd_cke && sd_cs_n && !host_ready && !host_rvalid && !sd_dq_oe, "R1 outputs in reset",
        {sd_cke, sd_cs_n, host_ready, host_rvalid, sd_dq_oe}, 5'b11000);
    rst = 0;
    repeat (PWR / 2) @(negedge clk);
    chk(sd_cke && sd_cs_n && !host_ready && n_cmd == 0, "R1 quiet during power-up wait",
        {sd_cke, sd_cs_n, host_ready}, 3'b110);
  endtask

  task automatic t_init(input logic [11:0] exp_mode);
    int g = 0;
    while (!host_ready && g < 2000) begin @(negedge clk); g++; end
    chk(n_act == 0, "R10 request held in init starts no ACTIVE", n_act, 0);
    host_req = 0;
    chk(ilog_cyc[0] >= PWR, "R1 first command after power-up delay", ilog_cyc[0], PWR);
    chk(ilog_cmd[0] == 3'b010 && ilog_a[0][10], "R2 precharge-all first", {ilog_cmd[0], ilog_a[0]}, {3'b010, 12'h400});
    chk(ilog_cmd[1] == 3'b001 && ilog_cmd[2] == 3'b001, "R2 two refreshes", {ilog_cmd[1], ilog_cmd[2]}, 6'b001001);
    chk(ilog_cmd[3] == 3'b000, "R2 load mode fourth", ilog_cmd[3], 0);
    chk(ilog_cyc[1] - ilog_cyc[0] == TRP && ilog_cyc[2] - ilog_cyc[1] == TRFC &&
        ilog_cyc[3] - ilog_cyc[2] == TRFC, "R2 init spacing", ilog_cyc[3] - ilog_cyc[0], TRP + 2 * TRFC);
    chk(ilog_a[3] == exp_mode, "R3/R11 mode word", ilog_a[3], exp_mode);
  endtask

  task automatic t_roundtrip(input int exp_lat);
    logic [21:0] ad [4] = '{22'h000000, 22'h3FFFFF, {2'd1, 12'h5A5, 8'h3C}, {2'd2, 12'h001, 8'h80}};
    logic [31:0] rd;
    int lat;
    for (int i = 0; i < 4; i++)
      host_access(1, ad[i], 32'hC0DE0000 + i * 32'h1111, 4'hF, 0, rd, lat);
    for (int i = 0; i < 4; i++) begin
      chk(mem.exists(ad[i]) && mem[ad[i]] == 32'hC0DE0000 + i * 32'h1111,
          "R4 stored at {bank,row,col}", mem.exists(ad[i]) ? mem[ad[i]] : 0, 32'hC0DE0000 + i * 32'h1111);
      host_access(0, ad[i], 32'h0, 4'h0, 0, rd, lat);
      chk(rd == 32'hC0DE0000 + i * 32'h1111, "R7 read data", rd, 32'hC0DE0000 + i * 32'h1111);
      chk(lat == exp_lat, "R7/R11 read latency", lat, exp_lat);
    end
    chk(a10_bad == 0, "R4 A10 high on column commands", a10_bad, 0);
  endtask

  task automatic t_mask();
    logic [31:0] rd;
    int lat;
    host_access(1, {2'd3, 12'h0AB, 8'h10}, 32'h11223344, 4'hF, 0, rd, lat);
    host_access(1, {2'd3, 12'h0AB, 8'h10}, 32'hAABBCCDD, 4'b0101, 0, rd, lat);
    host_access(0, {2'd3, 12'h0AB, 8'h10}, 32'h0, 4'h0, 0, rd, lat);
    chk(rd == 32'h11BB33DD, "R6 masked bytes kept", rd, 32'h11BB33DD);
  endtask

  task automatic t_hold_ignored();
    logic [31:0] rd;
    int lat, a0;
    a0 = n_act;
    host_access(1, {2'd0, 12'h222, 8'h22}, 32'h5555AAAA, 4'hF, 3, rd, lat);
    repeat (12) @(negedge clk);
    chk(n_act - a0 == 1, "R10 held request while busy ignored", n_act - a0, 1);
  endtask

  task automatic t_refresh_idle();
    int r0;
    r0 = n_ref;
    repeat (2000) @(negedge clk);
    chk(n_ref - r0 >= 4 && n_ref - r0 <= 6, "R8 refresh rate when idle", n_ref - r0, 5);
  endtask

  task automatic t_refresh_stream();
    logic [31:0] rd;
    int lat, start;
    start = cyc;
    for (int i = 0; cyc - start < 1500 && i < 400; i++)
      host_access(i[0], {2'(i), 12'(i * 7), 8'(i)}, 32'(i), 4'hF, 0, rd, lat);
    chk(max_ref_gap <= RI + 20, "R9 refresh not starved by requests", max_ref_gap, RI + 20);
    chk(viol == 0, "R5 command spacing and order", viol, 0);
  endtask

  initial begin
    t_reset(1'b1);
    t_init(12'h030);
    t_roundtrip(TRCD + 1 + 3);
    t_mask();
    t_hold_ignored();
    t_refresh_idle();
    t_refresh_stream();
    t_reset(1'b0);
    t_init(12'h020);
    t_roundtrip(TRCD + 1 + 2);
    chk(viol == 0, "R5 spacing with latency 2", viol, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule